// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt lines from board peripherals and reduces them to a single 4-bit encoded interrupt level for a processor. Each line is synchronised and stored in a 16-bit monitor word at a fixed bit position. Software enables lines through a 16-bit mask register. Among the lines that are both active and enabled, the one with the smallest priority number wins. That number is inverted in four bits and driven out, so an idle board shows zero on the level pins.

A small 16-bit register window sits beside the encoder. It holds the mask, a general output port whose low byte drives board pins, a version word that cannot be written, and a power-off register. Writing a 1 to bit 0 of the power-off register produces a one-cycle request pulse. Accesses use a plain synchronous bus with an address, separate read and write enables and 16-bit data. Read data is registered.

Top module: `brd_irq_lvl_top`

## Requirements
- R1: After synchronous active-high reset, `irl_o` is 0, `gpo_o` is 0, `pwr_off_o` is 0, and the mask register reads 0.
- R2: Input `irq_src_i[k]` maps to monitor/mask bit position B(k). B(0..12) = 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Monitor bits 1, 2 and 3 belong to no source. A source's monitor bit is 1 while its input is high and 0 while it is low.
- R3: A source qualifies only when its bit is set in both the monitor and the mask. The priority number of `irq_src_i[k]` is k. The selected number is the smallest k among qualifying sources, or 15 when no source qualifies.
- R4: `irl_o` equals the selected number XOR 15. No qualifying source gives 0, and source 0 gives 15.
- R5: A change on `irq_src_i` reaches `irl_o` on the third rising edge after it is applied: two synchroniser edges, then the output register. A mask write reaches `irl_o` on the edge after the write edge.
- R6: The mask register at byte offset 0x00 is read/write over all 16 bits.
- R7: The output-port register at offset 0x36 is read/write over all 16 bits. Its low 8 bits drive `gpo_o` from the write edge onward.
- R8: Offset 0x30 always reads 0. A write there with bit 0 set makes `pwr_off_o` high for exactly the cycle after the write edge. A write with bit 0 clear leaves `pwr_off_o` low.
- R9: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R10: Read data appears on `bus_rdata_o` after the edge where `bus_rd_i` is high and holds until the next read. Any unlisted offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 6 | Byte offset within the 0x40-byte window |
| bus_wr_i | input | 1 | Write enable |
| bus_rd_i | input | 1 | Read enable |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_src_i | input | 13 | Level interrupt inputs, index = priority number |
| irl_o | output | 4 | Inverted encoded interrupt level |
| gpo_o | output | 8 | Low byte of the output-port register |
| pwr_off_o | output | 1 | One-cycle power-off request |

## Verification
An input change is due on `irl_o` three edges after it is applied. A mask write is due one edge after the write edge. Register write effects on `gpo_o` and `pwr_off_o` are due at the write edge itself, and read data is due at the edge that samples the read enable. The bench drives each stimulus just after a rising edge and counts edges explicitly before sampling. For the latency cases it also samples one edge early, to show that the old value is still present. Vector-table cases wait for full settling before they compare.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
   localparam int NSRC  = 13;
   localparam int LVL_W = 4;
   localparam int MON_W = 16;

   localparam logic [5:0] OFS_MASK = 6'h00;
   localparam logic [5:0] OFS_PWR  = 6'h30;
   localparam logic [5:0] OFS_VER  = 6'h32;
   localparam logic [5:0] OFS_PORT = 6'h36;
   localparam logic [15:0] VER_WORD = 16'h0010;
   localparam logic [LVL_W-1:0] LVL_NONE = 4'hF;

   // monitor/mask bit position of each source; source index is its priority
   function automatic int unsigned src_bit(input int unsigned k);
      case (k)
         0:  return 11;
         1:  return 9;
         2:  return 8;
         3:  return 12;
         4:  return 10;
         5:  return 6;
         6:  return 5;
         7:  return 4;
         8:  return 7;
         9:  return 14;
         10: return 13;
         11: return 0;
         12: return 15;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
   parameter int W      = 13,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      if (STAGES < 1) $error("brd_irq_sync: STAGES must be at least 1");
      if (W < 1)      $error("brd_irq_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg[0] <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg <= {stg[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/brd_irq_prio.sv
module brd_irq_prio
   import brd_irq_pkg::*;
(
   input  logic [MON_W-1:0] mon,
   input  logic [MON_W-1:0] mask,
   output logic [LVL_W-1:0] enc
);
   logic [MON_W-1:0] gated;
   logic [NSRC-1:0]  hit;
   logic [LVL_W-1:0] sel;

   assign gated = mon & mask;

   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_hit
         assign hit[k] = gated[src_bit(k)];
      end
   endgenerate

   always_comb begin
      sel = LVL_NONE;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (hit[k]) sel = LVL_W'(k);
      end
   end

   assign enc = sel ^ LVL_NONE;
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
   import brd_irq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int OUT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mask_q,
   output logic [OUT_W-1:0]  gpo,
   output logic              pwr_pulse
);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFS_PWR);
   localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFS_VER);
   localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);

   logic [DATA_W-1:0] port_q;
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q    <= '0;
         port_q    <= '0;
         pwr_pulse <= 1'b0;
      end else begin
         pwr_pulse <= wr && (addr == A_PWR) && wdata[0];
         if (wr && addr == A_MASK) mask_q <= wdata;
         if (wr && addr == A_PORT) port_q <= wdata;
      end
   end

   always_comb begin
      unique case (addr)
         A_MASK:  rd_mux = mask_q;
         A_PORT:  rd_mux = port_q;
         A_VER:   rd_mux = DATA_W'(VER_WORD);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (rd) rdata <= rd_mux;
   end

   assign gpo = port_q[OUT_W-1:0];
endmodule

// File: rtl/brd_irq_lvl_top.sv
module brd_irq_lvl_top
   import brd_irq_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int OUT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [NSRC-1:0]   irq_src_i,
   output logic [LVL_W-1:0]  irl_o,
   output logic [OUT_W-1:0]  gpo_o,
   output logic              pwr_off_o
);
   localparam int PRE_STAGES = SYNC_STAGES - 1;

   initial begin
      if (SYNC_STAGES < 2)  $error("brd_irq_lvl_top: SYNC_STAGES must be at least 2");
      if (DATA_W != MON_W)  $error("brd_irq_lvl_top: DATA_W must equal the monitor width");
      if (ADDR_W < 6)       $error("brd_irq_lvl_top: ADDR_W must cover the 0x40 window");
      if (OUT_W > DATA_W)   $error("brd_irq_lvl_top: OUT_W exceeds DATA_W");
   end

   logic [NSRC-1:0]   src_s;
   logic [MON_W-1:0]  mon_d;
   logic [MON_W-1:0]  mon_q;
   logic [DATA_W-1:0] mask_q;
   logic [LVL_W-1:0]  enc;

   brd_irq_sync #(.W(NSRC), .STAGES(PRE_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (irq_src_i),
      .dout (src_s)
   );

   always_comb begin
      mon_d = '0;
      for (int k = 0; k < NSRC; k++) mon_d[src_bit(k)] = src_s[k];
   end

   always_ff @(posedge clk) begin
      if (rst) mon_q <= '0;
      else     mon_q <= mon_d;
   end

   brd_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .addr      (bus_addr_i),
      .wr        (bus_wr_i),
      .rd        (bus_rd_i),
      .wdata     (bus_wdata_i),
      .rdata     (bus_rdata_o),
      .mask_q    (mask_q),
      .gpo       (gpo_o),
      .pwr_pulse (pwr_off_o)
   );

   brd_irq_prio u_prio (
      .mon  (mon_q),
      .mask (mask_q),
      .enc  (enc)
   );

   always_ff @(posedge clk) begin
      if (rst) irl_o <= '0;
      else     irl_o <= enc;
   end
endmodule

// File: rtl/brd_irq_lvl_chk.sv
module brd_irq_lvl_chk
   import brd_irq_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic [5:0]        addr,
   input logic              wr,
   input logic              rd,
   input logic [15:0]       wdata,
   input logic [15:0]       rdata,
   input logic [3:0]        irl,
   input logic [7:0]        gpo,
   input logic              pwr,
   input logic [15:0]       mon,
   input logic [15:0]       mask
);
   // R8: a pulse only follows a qualifying power-off write
   a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
      pwr |-> $past(wr && addr == OFS_PWR && wdata[0]));

   // R8: power-off offset reads zero
   a_r8_reads_zero: assert property (@(posedge clk) disable iff (rst)
      $past(rd && addr == OFS_PWR) |-> rdata == 16'h0000);

   // R9: version word is constant
   a_r9_version: assert property (@(posedge clk) disable iff (rst)
      $past(rd && addr == OFS_VER) |-> rdata == VER_WORD);

   // R4: nothing qualifying gives an idle level
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
      $past((mon & mask) == 16'h0000) |-> irl == 4'h0);

   // R7: pins move only on a port write
   a_r7_pins_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(wr && addr == OFS_PORT) |-> $stable(gpo));

   // R10: read data holds without a read
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(rd) |-> $stable(rdata));
endmodule

bind brd_irq_lvl_top brd_irq_lvl_chk u_chk (
   .clk   (clk),
   .rst   (rst),
   .addr  (bus_addr_i),
   .wr    (bus_wr_i),
   .rd    (bus_rd_i),
   .wdata (bus_wdata_i),
   .rdata (bus_rdata_o),
   .irl   (irl_o),
   .gpo   (gpo_o),
   .pwr   (pwr_off_o),
   .mon   (mon_q),
   .mask  (mask_q)
);

// File: tb/brd_irq_lvl_top_tb_top.sv
module brd_irq_lvl_top_tb_top;
   localparam int CLK_P = 10;
   localparam int NV    = 11;
   // {mask, sources, expected irl}
   localparam logic [32:0] VEC [NV] = '{
      {16'hFFFF, 13'h0000, 4'h0},  // nothing active
      {16'hFFFF, 13'h0001, 4'hF},  // source 0 -> 15
      {16'hFFFF, 13'h1000, 4'h3},  // source 12 -> 3
      {16'hFFFF, 13'h0220, 4'hA},  // sources 5 and 9 -> 5
      {16'h0000, 13'h1FFF, 4'h0},  // all masked
      {16'h0800, 13'h1FFF, 4'hF},  // only bit 11 enabled
      {16'h7FFF, 13'h1000, 4'h0},  // bit 15 masked
      {16'h0001, 13'h1FFF, 4'h4},  // bit 0 -> source 11
      {16'hF7FF, 13'h1FFF, 4'hE},  // source 0 masked -> 1
      {16'h000E, 13'h1FFF, 4'h0},  // unowned bits
      {16'h4000, 13'h0600, 4'h6}   // bit 14 -> source 9
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  bus_addr_i = '0;
   logic        bus_wr_i = 1'b0;
   logic        bus_rd_i = 1'b0;
   logic [15:0] bus_wdata_i = '0;
   logic [15:0] bus_rdata_o;
   logic [12:0] irq_src_i = '0;
   logic [3:0]  irl_o;
   logic [7:0]  gpo_o;
   logic        pwr_off_o;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   brd_irq_lvl_top dut_i (
      .clk(clk), .rst(rst), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
      .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .irq_src_i(irq_src_i), .irl_o(irl_o), .gpo_o(gpo_o), .pwr_off_o(pwr_off_o)
   );

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
      step(1);
      bus_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr_i = a; bus_rd_i = 1'b1;
      step(1);
      bus_rd_i = 1'b0;
      d = bus_rdata_o;
   endtask

   initial begin
      #(CLK_P * 200000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      step(3);
      rst = 1'b0;
      // R1 reset state
      chk("R1 irl", 16'(irl_o), 16'h0);
      chk("R1 gpo", 16'(gpo_o), 16'h0);
      chk("R1 pwr", 16'(pwr_off_o), 16'h0);
      rd(6'h00, d); chk("R1 mask", d, 16'h0000);

      // R2 R3 R4 vector table
      for (int i = 0; i < NV; i++) begin
         wr(6'h00, VEC[i][32:17]);
         irq_src_i = VEC[i][16:4];
         step(3);
         chk($sformatf("R2/R3/R4 vec%0d", i), 16'(irl_o), 16'(VEC[i][3:0]));
      end

      // R5 input latency
      wr(6'h00, 16'hFFFF);
      irq_src_i = 13'h0000;
      step(3);
      irq_src_i = 13'h0001;
      step(2);
      chk("R5 input early", 16'(irl_o), 16'h0);
      step(1);
      chk("R5 input due", 16'(irl_o), 16'hF);
      // R5 mask latency
      irq_src_i = 13'h1FFF;
      step(3);
      wr(6'h00, 16'h0001);
      chk("R5 mask early", 16'(irl_o), 16'hF);
      step(1);
      chk("R5 mask due", 16'(irl_o), 16'h4);

      // R6 mask readback
      wr(6'h00, 16'hA5C3);
      rd(6'h00, d); chk("R6 mask rw", d, 16'hA5C3);

      // R7 output port
      wr(6'h36, 16'hB45A);
      chk("R7 pins", 16'(gpo_o), 16'h005A);
      rd(6'h36, d); chk("R7 port rw", d, 16'hB45A);

      // R8 power-off
      wr(6'h30, 16'h0001);
      chk("R8 pulse", 16'(pwr_off_o), 16'h1);
      step(1);
      chk("R8 pulse end", 16'(pwr_off_o), 16'h0);
      wr(6'h30, 16'hFFFE);
      chk("R8 no pulse", 16'(pwr_off_o), 16'h0);
      rd(6'h30, d); chk("R8 reads zero", d, 16'h0000);

      // R9 version
      rd(6'h32, d); chk("R9 version", d, 16'h0010);
      wr(6'h32, 16'hFFFF);
      rd(6'h32, d); chk("R9 write ignored", d, 16'h0010);
      rd(6'h36, d); chk("R9 port untouched", d, 16'hB45A);

      // R10 unlisted offset and hold
      rd(6'h10, d); chk("R10 unlisted", d, 16'h0000);
      rd(6'h36, d);
      step(2);
      chk("R10 hold", bus_rdata_o, 16'hB45A);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule